// File: doc/BRIEF.md
# Sum-Addressed Cache Row Decoder

This block selects the word line of a direct-mapped data cache row straight from a base register value and an offset. It does not first form the effective address in a carry-propagating adder. Each row carries its own fixed row number and tests, without any carry chain, whether the two operands add up to that number. The default geometry is a 16 KB cache of 8-byte doublewords: 14-bit operands, a 3-bit byte field and an 11-bit row index.

The rows are split into an even bank and an odd bank. The carry out of the byte field is not known when the row tests start. To absorb it, each bank asserts the single row that could hold the line for either value of that carry. The even bank covers index sums 2N-1 and 2N with line 2N. The odd bank covers index sums 2N and 2N+1 with line 2N+1. Both banks deliver a line. A low-order carry flag and a bank pick flag then say which of the two is the line actually addressed.

Operands are registered on the clock edge when the valid strobe is high. The word lines are combinational from the registered operands. A consumer reads both banks in parallel and steers the result with the pick flag.

Top module: `sad_row_decoder`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises with no valid strobe, every word line, lo_carry and odd_pick are 0.
- R2: base, offset and in_valid are sampled on the rising clock edge. When the sampled in_valid is 0, every word line, lo_carry and odd_pick are 0 until the next edge, whatever the operand values.
- R3: Let I be (base[13:3] + offset[13:3]) mod 2048. With valid sampled, even_wl has exactly bit ((I+1) mod 2048) >> 1 set.
- R4: With valid sampled, odd_wl has exactly bit I >> 1 set.
- R5: With valid sampled, lo_carry is 1 exactly when base[2:0] + offset[2:0] is 8 or more.
- R6: Let L = (I + lo_carry) mod 2048 be the addressed line. odd_pick equals bit 0 of L. The bank named by odd_pick (1 for odd, 0 for even) has bit L >> 1 set.
- R7: The index wraps. When I is all ones, even_wl selects row 0 and odd_wl selects the top row. If lo_carry is also 1, the addressed line is line 0 in the even bank.
- R8: With valid sampled, each bank is strictly one-hot. The even row equals either the odd row or the odd row plus one, modulo the rows per bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| base | input | ADDR_W (14) | Base register value |
| offset | input | ADDR_W (14) | Address offset |
| even_wl | output | 2^(ADDR_W-OFF_W-1) (1024) | One-hot word lines of the even-line bank |
| odd_wl | output | 2^(ADDR_W-OFF_W-1) (1024) | One-hot word lines of the odd-line bank |
| lo_carry | output | 1 | Carry out of the byte-in-doubleword field |
| odd_pick | output | 1 | 1 when the addressed line is in the odd bank |

## Verification
The one-hot and bank-adjacency properties assume that reset is applied before the first valid strobe. They also assume that base and offset hold known 0/1 values whenever in_valid is high, because a single unknown bit would spread into many row tests at once. The stimulus holds reset for several cycles first and drives only defined values, including on idle cycles. It walks the index sum through zero, the all-ones value, wrap-around of the index sum, and the byte-field carry both set and clear, then runs random operands with random gaps in the strobe.

// File: rtl/sad_pkg.sv
package sad_pkg;

   // Default geometry: 16 KB direct-mapped, 8-byte lines.
   localparam int unsigned SAD_ADDR_W_DEF = 14;
   localparam int unsigned SAD_OFF_W_DEF  = 3;

   // Bank identity; picks the low-order carry-in form of a bank's row tests.
   typedef enum logic {
      BANK_EVEN = 1'b0,
      BANK_ODD  = 1'b1
   } sad_bank_e;

endpackage

// File: rtl/sad_opnd_reg.sv
module sad_opnd_reg #(
   parameter int unsigned ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic              q_valid,
   output logic [ADDR_W-1:0] q_base,
   output logic [ADDR_W-1:0] q_off
);

   // Operands load only on a valid cycle; they hold otherwise to limit toggling.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_base  <= '0;
         q_off   <= '0;
      end else begin
         q_valid <= in_valid;
         if (in_valid) begin
            q_base <= base;
            q_off  <= offset;
         end
      end
   end

endmodule

// File: rtl/sad_lo_carry.sv
module sad_lo_carry #(
   parameter int unsigned OFF_W = 3
) (
   input  logic [OFF_W-1:0] a_lo,
   input  logic [OFF_W-1:0] b_lo,
   output logic             cout
);

   logic [OFF_W:0] cy;

   assign cy[0] = 1'b0;

   // Short ripple across the byte field; it runs beside the row tests.
   generate
      for (genvar i = 0; i < OFF_W; i++) begin : g_bit
         assign cy[i+1] = (a_lo[i] & b_lo[i]) | ((a_lo[i] ^ b_lo[i]) & cy[i]);
      end
   endgenerate

   assign cout = cy[OFF_W];

endmodule

// File: rtl/sad_row_match.sv
module sad_row_match #(
   parameter int unsigned W = 10,
   parameter int unsigned K = 0
) (
   input  logic [W-1:0] a_hi,
   input  logic [W-1:0] b_hi,
   input  logic         c0,
   output logic         hit
);

   localparam logic [W-1:0] KV = W'(K);

   logic [W-2:0] gen_c;
   logic [W-1:0] half;
   logic [W-1:0] carry;

   // Majority of (a, b, ~k). With k constant it reduces to AND (k=1) or OR (k=0).
   generate
      for (genvar j = 0; j < W - 1; j++) begin : g_maj
         if (KV[j]) begin : g_and
            assign gen_c[j] = a_hi[j] & b_hi[j];
         end else begin : g_or
            assign gen_c[j] = a_hi[j] | b_hi[j];
         end
      end
   endgenerate

   // XOR with a constant leaves a plain XOR or XNOR per bit.
   assign half  = a_hi ^ b_hi ^ KV;
   // Bit 0 of the carry word is free, so the carry from below enters there.
   assign carry = {gen_c, c0};
   // a + b + c0 == K holds exactly when the two words agree bit for bit.
   assign hit   = (half == carry);

endmodule

// File: rtl/sad_bank_decoder.sv
module sad_bank_decoder
   import sad_pkg::*;
#(
   parameter int unsigned W    = 10,
   parameter sad_bank_e   BANK = BANK_EVEN
) (
   input  logic [W:0]        a_idx,
   input  logic [W:0]        b_idx,
   input  logic              valid,
   output logic [(1<<W)-1:0] wl
);

   localparam int unsigned ROWS = 1 << W;

   logic              c0;
   logic [ROWS-1:0]   hit;

   // The index LSB is folded into a carry into the upper bits:
   // even bank tests (I+1)>>1, odd bank tests I>>1.
   generate
      if (BANK == BANK_EVEN) begin : g_even
         assign c0 = a_idx[0] | b_idx[0];
      end else begin : g_odd
         assign c0 = a_idx[0] & b_idx[0];
      end
   endgenerate

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         sad_row_match #(
            .W (W),
            .K (r)
         ) u_match (
            .a_hi (a_idx[W:1]),
            .b_hi (b_idx[W:1]),
            .c0   (c0),
            .hit  (hit[r])
         );
      end
   endgenerate

   assign wl = hit & {ROWS{valid}};

endmodule

// File: rtl/sad_row_decoder.sv
module sad_row_decoder
   import sad_pkg::*;
#(
   parameter int unsigned ADDR_W = SAD_ADDR_W_DEF,
   parameter int unsigned OFF_W  = SAD_OFF_W_DEF
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [ADDR_W-1:0]                    base,
   input  logic [ADDR_W-1:0]                    offset,
   output logic [(1<<(ADDR_W-OFF_W-1))-1:0]     even_wl,
   output logic [(1<<(ADDR_W-OFF_W-1))-1:0]     odd_wl,
   output logic                                 lo_carry,
   output logic                                 odd_pick
);

   localparam int unsigned IDX_W  = ADDR_W - OFF_W;
   localparam int unsigned HALF_W = IDX_W - 1;
   localparam int unsigned ROWS   = 1 << HALF_W;

   generate
      if (OFF_W < 1) begin : g_chk_off
         $error("sad_row_decoder: OFF_W must be at least 1");
      end
      if (ADDR_W < OFF_W + 3) begin : g_chk_idx
         $error("sad_row_decoder: index field must be at least 3 bits");
      end
   endgenerate

   logic              q_valid;
   logic [ADDR_W-1:0] q_base;
   logic [ADDR_W-1:0] q_off;
   logic              cout;

   sad_opnd_reg #(
      .ADDR_W (ADDR_W)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .base     (base),
      .offset   (offset),
      .q_valid  (q_valid),
      .q_base   (q_base),
      .q_off    (q_off)
   );

   sad_lo_carry #(
      .OFF_W (OFF_W)
   ) u_lo (
      .a_lo (q_base[OFF_W-1:0]),
      .b_lo (q_off[OFF_W-1:0]),
      .cout (cout)
   );

   sad_bank_decoder #(
      .W    (HALF_W),
      .BANK (BANK_EVEN)
   ) u_even (
      .a_idx (q_base[ADDR_W-1:OFF_W]),
      .b_idx (q_off[ADDR_W-1:OFF_W]),
      .valid (q_valid),
      .wl    (even_wl)
   );

   sad_bank_decoder #(
      .W    (HALF_W),
      .BANK (BANK_ODD)
   ) u_odd (
      .a_idx (q_base[ADDR_W-1:OFF_W]),
      .b_idx (q_off[ADDR_W-1:OFF_W]),
      .valid (q_valid),
      .wl    (odd_wl)
   );

   assign lo_carry = q_valid & cout;
   // Parity of the addressed line: index LSB of the sum plus the byte-field carry.
   assign odd_pick = q_valid & (q_base[OFF_W] ^ q_off[OFF_W] ^ cout);

   AST_EVEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ($countones(even_wl) == 1)); // R8
   AST_ODD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ($countones(odd_wl) == 1)); // R8
   AST_BANK_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ((even_wl == odd_wl) ||
                   (even_wl == {odd_wl[ROWS-2:0], odd_wl[ROWS-1]}))); // R8
   AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> ((even_wl == '0) && (odd_wl == '0) && !lo_carry && !odd_pick)); // R2
   AST_PICK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && !lo_carry) |-> (odd_pick ? (even_wl != odd_wl) : (even_wl == odd_wl))); // R6

endmodule

// File: tb/sad_row_decoder_tb_top.sv
module sad_row_decoder_tb_top;

   localparam int ADDR_W     = 14;
   localparam int OFF_W      = 3;
   localparam int IDX_W      = ADDR_W - OFF_W;
   localparam int HALF_W     = IDX_W - 1;
   localparam int ROWS       = 1 << HALF_W;
   localparam int IDX_MOD    = 1 << IDX_W;
   localparam int OFF_MOD    = 1 << OFF_W;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit         v;
      logic [ADDR_W-1:0] b;
      logic [ADDR_W-1:0] o;
      string      tag;
   } stim_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [ADDR_W-1:0] base = '0;
   logic [ADDR_W-1:0] offset = '0;
   logic [ROWS-1:0]   even_wl;
   logic [ROWS-1:0]   odd_wl;
   logic              lo_carry;
   logic              odd_pick;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;
   stim_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sad_row_decoder #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .base     (base),
      .offset   (offset),
      .even_wl  (even_wl),
      .odd_wl   (odd_wl),
      .lo_carry (lo_carry),
      .odd_pick (odd_pick)
   );

   task automatic chk_vec(input string req, input logic [ROWS-1:0] act, input logic [ROWS-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   endtask

   // Reference: plain integer add of the operands, then a one-hot shift.
   task automatic compare(input stim_t s);
      int unsigned ia, ib, isum, lo, line, erow, orow;
      logic [ROWS-1:0] one;
      logic [ROWS-1:0] exp_e, exp_o, chosen;
      one  = 1;
      ia   = int'(s.b >> OFF_W);
      ib   = int'(s.o >> OFF_W);
      isum = (ia + ib) % IDX_MOD;
      lo   = ((int'(s.b) % OFF_MOD) + (int'(s.o) % OFF_MOD)) >= OFF_MOD ? 1 : 0;
      line = (isum + lo) % IDX_MOD;
      erow = ((isum + 1) % IDX_MOD) >> 1;
      orow = isum >> 1;
      exp_e = s.v ? (one << erow) : '0;
      exp_o = s.v ? (one << orow) : '0;
      chk_vec({"R3 even row ", s.tag}, even_wl, exp_e);
      chk_vec({"R4 odd row ", s.tag}, odd_wl, exp_o);
      chk_bit({"R5 lo_carry ", s.tag}, lo_carry, s.v ? logic'(lo) : 1'b0);
      chk_bit({"R6 odd_pick ", s.tag}, odd_pick, s.v ? logic'(line % 2) : 1'b0);
      if (s.v) begin
         chosen = odd_pick ? odd_wl : even_wl;
         chk_bit({"R6 addressed line ", s.tag}, chosen[line >> 1], 1'b1);
      end
   endtask

   task automatic step(input bit v, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] o, input string tag);
      stim_t s;
      s.v = v; s.b = b; s.o = o; s.tag = tag;
      in_valid = v;
      base     = b;
      offset   = o;
      exp_q.push_back(s);
      @(posedge clk);
      @(negedge clk);
      compare(exp_q.pop_front());
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [ADDR_W-1:0] idx_max;
      idx_max = {{IDX_W{1'b1}}, {OFF_W{1'b0}}};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_vec("R1 reset even", even_wl, '0);
      chk_vec("R1 reset odd", odd_wl, '0);
      chk_bit("R1 reset lo_carry", lo_carry, 1'b0);
      chk_bit("R1 reset odd_pick", odd_pick, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_vec("R1 after release", even_wl | odd_wl, '0);

      step(1'b1, '0, '0, "zero index");
      step(1'b1, idx_max, '0, "R7 all-ones no carry");
      step(1'b1, idx_max | 14'd7, 14'd1, "R7 all-ones with carry");
      step(1'b1, 14'd5, 14'd3, "R5 carry set");
      step(1'b1, 14'd3, 14'd4, "R5 carry clear");
      step(1'b0, 14'h1ABC, 14'h0F0F, "R2 idle nonzero operands");
      step(1'b1, 14'h2000, 14'h2000, "R7 index sum wrap");
      step(1'b1, 14'h1FF8, 14'h0008, "R7 carry into top");
      step(1'b0, 14'h3FFF, 14'h3FFF, "R2 idle all ones");
      step(1'b1, 14'h3FFF, 14'h3FFF, "R7 both all ones");

      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 5) != 0, ADDR_W'($urandom), ADDR_W'($urandom), "R8 random");
      end
      finish_run();
   end

endmodule